// File: doc/BRIEF.md
# Programmable March-Test RAM Self-Test Controller

This block runs memory tests on a single-port RAM with synchronous read. The test is not fixed in hardware. It is a short program of march commands that is shifted in serially before the run. Each command names three things: the direction to walk the addresses, a code for the operations applied at each address, and the data background. The controller then carries out the commands one after another, starting from the first.

Two state machines share the work. A control machine handles loading, start and handover. A pattern generator fetches each command, walks the addresses, issues reads and writes, and compares each read word with the expected value. The program ends in one of three ways:

- A null command ends the test with a pass.
- Running past the last command slot also ends the test with a pass.
- The first mismatching read stops everything in a fail state. Only reset leaves that state.

Top module: `march_seq_bist`

## Requirements
- R1: After a synchronous reset the block is idle and its outputs are low: `mem_en`, `mem_we`, `test_done` and `test_pass` are 0. Every command slot is cleared to all zeros, so every slot reads as a null command.
- R2: Loading works as follows.
  - While `scan_en` is 1 and no test is running, one bit of `scan_in` is taken on each clock.
  - After CMD_DEPTH×(5+DATA_W) bits, command k holds the bits taken at positions k×(5+DATA_W) onward, least significant bit first.
  - In each command, bit 0 is the direction, bits 4:1 are the operation code, and bits 4+DATA_W:5 are the background `a`.
- R3: Direction 0 visits addresses 0 up to 2^ADDR_W−1. Direction 1 visits them from 2^ADDR_W−1 down to 0. All operations of the command are applied at one address before moving to the next.
- R4: The operation codes apply these sequences at each address, where `a'` is the bitwise complement of `a`:

  | Code | Sequence |
  |---|---|
  | 1 | write a |
  | 2 | read a |
  | 3 | read a, write a' |
  | 4 | read a, write a', read a' |
  | 5 | write a, read a, write a', read a' |

  A write drives the data on `mem_wdata`. A read expects that data on `mem_rdata`.
- R5: Codes 6 to 15 are skipped without any RAM access, and the next command is fetched.
- R6: Code 0 is the null command. It ends the test with `test_done`=1 and `test_pass`=1, whatever the other fields hold. No RAM access follows.
- R7: If every slot is used and none is null, the test ends with `test_done`=1 and `test_pass`=1.
- R8: A read whose data differs from the expected word ends the test with `test_done`=1 and `test_pass`=0. After that, no RAM access occurs and `start` has no effect. The state holds until reset.
- R9: While a test runs, `scan_en`, `scan_in` and `start` are ignored, and the loaded commands stay unchanged.
- R10: After a passing test, a `start` pulse clears `test_done` and `test_pass`. It then reruns the same loaded commands.
- R11: `mem_we` is 1 only together with `mem_en`. Every read request is followed by one cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the only exit from the fail state |
| start | input | 1 | Starts the loaded program when idle |
| scan_en | input | 1 | Command loading enable |
| scan_in | input | 1 | Serial command bit |
| mem_en | output | 1 | RAM request |
| mem_we | output | 1 | RAM write select (1 write, 0 read) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after the read request |
| test_done | output | 1 | Test finished |
| test_pass | output | 1 | Result when finished: 1 pass, 0 fail |

## Verification
A wrong walking address, step counter or command pointer appears at the RAM ports as soon as it occurs. Because every request is compared in order with an expected operation list, the first wrong address, wrong direction of access or wrong data word is reported in the very cycle it is issued. A wrong fetch decision, such as a mis-decoded null or skipped code, shows either as an extra or missing request or as a wrong `test_pass` a few cycles after the last expected access. A fail state that does not hold is caught by the `start` pulse and the quiet window that follow a fail.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    CS_IDLE, CS_SHIFT, CS_GET, CS_APPLY
  } ctrl_state_t;

  typedef enum logic [3:0] {
    TS_IDLE, TS_INIT, TS_IFETCH, TS_DFETCH, TS_EXEC,
    TS_RWAIT, TS_CMP, TS_FIN, TS_NOGO
  } tpg_state_t;

  // one memory operation of a sequence
  typedef struct packed {
    logic wr;   // 1 write, 0 read
    logic inv;  // 1 complemented background
  } mop_t;

  // number of operations per address, 0 for codes that are skipped
  function automatic logic [2:0] op_len(input logic [OP_W-1:0] code);
    case (code)
      4'd1, 4'd2: op_len = 3'd1;
      4'd3:       op_len = 3'd2;
      4'd4:       op_len = 3'd3;
      4'd5:       op_len = 3'd4;
      default:    op_len = 3'd0;
    endcase
  endfunction

  // all sequences are windows of: w a, r a, w a', r a'
  function automatic mop_t op_step(input logic [OP_W-1:0] code,
                                   input logic [1:0] step);
    logic [1:0] idx;
    idx = (code == 4'd5 || code == 4'd1) ? step : step + 2'd1;
    case (idx)
      2'd0:    op_step = '{wr: 1'b1, inv: 1'b0};
      2'd1:    op_step = '{wr: 1'b0, inv: 1'b0};
      2'd2:    op_step = '{wr: 1'b1, inv: 1'b1};
      default: op_step = '{wr: 1'b0, inv: 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/cmd_shift_buf.sv
module cmd_shift_buf #(
  parameter int CMD_W = 13,
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             shift_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CMD_W-1:0] rd_cmd
);
  localparam int TOT = CMD_W * DEPTH;

  logic [TOT-1:0]   chain_q;
  logic [CMD_W-1:0] slot [DEPTH];

  // new bit enters at the top, so the first bit ends up at bit 0
  always_ff @(posedge clk) begin
    if (rst)           chain_q <= '0;
    else if (shift_en) chain_q <= {shift_bit, chain_q[TOT-1:1]};
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot[g] = chain_q[g*CMD_W +: CMD_W];
  end

  assign rd_cmd = slot[rd_idx];
endmodule

// File: rtl/march_ctrl_fsm.sv
module march_ctrl_fsm
  import march_bist_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scan_en,
  input  logic tpg_fin,
  output logic shift_en,
  output logic clr_result,
  output logic tpg_en
);
  ctrl_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      CS_IDLE:  if (scan_en) st_d = CS_SHIFT;
                else if (start) st_d = CS_GET;
      CS_SHIFT: if (!scan_en) st_d = CS_IDLE;
      CS_GET:   st_d = CS_APPLY;
      CS_APPLY: if (tpg_fin) st_d = CS_IDLE;
      default:  st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= CS_IDLE;
    else     st_q <= st_d;
  end

  assign shift_en   = scan_en && (st_q == CS_IDLE || st_q == CS_SHIFT);
  assign clr_result = (st_q == CS_GET);
  assign tpg_en     = (st_q == CS_APPLY);
endmodule

// File: rtl/march_pattern_gen.sv
module march_pattern_gen
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int CMD_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] rdata,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fin,
  output logic              nogo
);
  localparam int PTR_W = IDX_W + 1;

  tpg_state_t        st_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              dir_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] bg_q, exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        step_q;
  logic              en_q, we_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [DATA_W-1:0] wdata_q;

  // fields of the command being fetched
  logic              f_dir;
  logic [OP_W-1:0]   f_op;
  logic [DATA_W-1:0] f_bg;
  assign f_dir = cmd[0];
  assign f_op  = cmd[OP_W:1];
  assign f_bg  = cmd[OP_W+DATA_W:OP_W+1];

  // current operation and the move to the next one
  mop_t              cur;
  logic [DATA_W-1:0] cur_data;
  logic              last_step, last_addr;
  tpg_state_t        adv_st;
  logic [1:0]        adv_step;
  logic [ADDR_W-1:0] adv_addr;
  logic [PTR_W-1:0]  adv_ptr;

  always_comb begin
    cur       = op_step(op_q, step_q);
    cur_data  = cur.inv ? ~bg_q : bg_q;
    last_step = ({1'b0, step_q} + 3'd1) >= op_len(op_q);
    last_addr = dir_q ? (addr_q == '0) : (addr_q == '1);
    adv_st    = TS_EXEC;
    adv_step  = step_q + 2'd1;
    adv_addr  = addr_q;
    adv_ptr   = ptr_q;
    if (last_step) begin
      adv_step = '0;
      if (last_addr) begin
        adv_st  = TS_IFETCH;
        adv_ptr = ptr_q + PTR_W'(1);
      end else begin
        adv_addr = dir_q ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= TS_IDLE;
      ptr_q   <= '0;
      dir_q   <= 1'b0;
      op_q    <= '0;
      bg_q    <= '0;
      exp_q   <= '0;
      addr_q  <= '0;
      step_q  <= '0;
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      maddr_q <= '0;
      wdata_q <= '0;
    end else begin
      en_q <= 1'b0;
      we_q <= 1'b0;
      case (st_q)
        TS_IDLE:  if (en) st_q <= TS_INIT;
        TS_INIT: begin
          ptr_q <= '0;
          st_q  <= TS_IFETCH;
        end
        TS_IFETCH: begin
          if (ptr_q == PTR_W'(DEPTH) || f_op == '0) begin
            st_q <= TS_FIN;
          end else if (op_len(f_op) == 3'd0) begin
            ptr_q <= ptr_q + PTR_W'(1);
          end else begin
            dir_q <= f_dir;
            op_q  <= f_op;
            bg_q  <= f_bg;
            st_q  <= TS_DFETCH;
          end
        end
        TS_DFETCH: begin
          addr_q <= dir_q ? '1 : '0;
          step_q <= '0;
          st_q   <= TS_EXEC;
        end
        TS_EXEC: begin
          en_q    <= 1'b1;
          we_q    <= cur.wr;
          maddr_q <= addr_q;
          wdata_q <= cur_data;
          exp_q   <= cur_data;
          if (cur.wr) begin
            st_q   <= adv_st;
            step_q <= adv_step;
            addr_q <= adv_addr;
            ptr_q  <= adv_ptr;
          end else begin
            st_q <= TS_RWAIT;
          end
        end
        TS_RWAIT: st_q <= TS_CMP;
        TS_CMP: begin
          if (rdata != exp_q) begin
            st_q <= TS_NOGO;
          end else begin
            st_q   <= adv_st;
            step_q <= adv_step;
            addr_q <= adv_addr;
            ptr_q  <= adv_ptr;
          end
        end
        TS_FIN:  if (!en) st_q <= TS_IDLE;
        TS_NOGO: st_q <= TS_NOGO;
        default: st_q <= TS_IDLE;
      endcase
    end
  end

  assign cmd_idx   = ptr_q[IDX_W-1:0];
  assign mem_en    = en_q;
  assign mem_we    = we_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = wdata_q;
  assign fin       = (st_q == TS_FIN);
  assign nogo      = (st_q == TS_NOGO);
endmodule

// File: rtl/march_seq_bist.sv
module march_seq_bist
  import march_bist_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CMD_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              scan_en,
  input  logic              scan_in,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              test_done,
  output logic              test_pass
);
  localparam int CMD_W = 1 + OP_W + DATA_W;
  localparam int IDX_W = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1;

  logic             shift_en, clr_result, tpg_en, tpg_fin, tpg_nogo;
  logic [IDX_W-1:0] cmd_idx;
  logic [CMD_W-1:0] cmd;
  logic             done_q, pass_q;

  march_ctrl_fsm u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .scan_en    (scan_en),
    .tpg_fin    (tpg_fin),
    .shift_en   (shift_en),
    .clr_result (clr_result),
    .tpg_en     (tpg_en)
  );

  cmd_shift_buf #(.CMD_W(CMD_W), .DEPTH(CMD_DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .shift_bit (scan_in),
    .rd_idx    (cmd_idx),
    .rd_cmd    (cmd)
  );

  march_pattern_gen #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (CMD_DEPTH),
    .IDX_W  (IDX_W),  .CMD_W  (CMD_W)
  ) u_tpg (
    .clk       (clk),
    .rst       (rst),
    .en        (tpg_en),
    .cmd       (cmd),
    .rdata     (mem_rdata),
    .cmd_idx   (cmd_idx),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .fin       (tpg_fin),
    .nogo      (tpg_nogo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (clr_result) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (tpg_fin) begin
      done_q <= 1'b1;
      pass_q <= 1'b1;
    end else if (tpg_nogo) begin
      done_q <= 1'b1;
      pass_q <= 1'b0;
    end
  end

  assign test_done = done_q;
  assign test_pass = pass_q;
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk (
  input logic clk,
  input logic rst,
  input logic mem_en,
  input logic mem_we,
  input logic test_done,
  input logic test_pass
);
  // R1: reset leaves the block quiet and without a result
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!test_done && !mem_en));

  // R11: write select only with a request
  a_r11_we_with_en: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  // R11: a read request is followed by a cycle with no request
  a_r11_read_gap: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> !mem_en);

  // R6: no RAM access while a result is shown
  a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    test_done |-> !mem_en);

  // R8: a fail result holds until reset
  a_r8_nogo_holds: assert property (@(posedge clk) disable iff (rst)
    (test_done && !test_pass) |=> (test_done && !test_pass));
endmodule

bind march_seq_bist march_bist_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .test_done (test_done),
  .test_pass (test_pass)
);

// File: tb/march_seq_bist_bench.sv
module march_seq_bist_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int ND = 4;
  localparam int CW = 5 + DW;
  localparam int NA = 1 << AW;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } op_rec_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
  logic mem_en, mem_we, test_done, test_pass;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  march_seq_bist #(.ADDR_W(AW), .DATA_W(DW), .CMD_DEPTH(ND)) u_march_seq_bist (
    .clk(clk), .rst(rst), .start(start), .scan_en(scan_en), .scan_in(scan_in),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .test_done(test_done), .test_pass(test_pass)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // RAM with an optional stuck bit seen on reads
  logic [DW-1:0] ram [NA];
  logic [DW-1:0] mdl_mem [NA];
  bit flt_on = 0;
  logic [AW-1:0] flt_addr = '0;
  int flt_bit = 0;
  logic flt_val = 1'b0;

  function automatic logic [DW-1:0] seen(input logic [DW-1:0] v, input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = v;
    if (flt_on && a == flt_addr) r[flt_bit] = flt_val;
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= seen(ram[mem_addr], mem_addr);
    end
  end

  // reference model: expected access list and result
  op_rec_t exp_q[$];
  bit exp_pass;

  function automatic logic [CW-1:0] mk(input logic d, input logic [3:0] op, input logic [DW-1:0] bg);
    return {bg, op, d};
  endfunction

  task automatic build(input logic [CW-1:0] c [ND]);
    exp_q.delete();
    for (int k = 0; k < ND; k++) begin
      logic d;
      logic [3:0] op;
      logic [DW-1:0] bg;
      int len;
      d = c[k][0]; op = c[k][4:1]; bg = c[k][CW-1:5];
      if (op == 0) begin exp_pass = 1; return; end
      case (op)
        1, 2: len = 1;
        3: len = 2;
        4: len = 3;
        5: len = 4;
        default: len = 0;
      endcase
      for (int i = 0; i < NA; i++) begin
        logic [AW-1:0] a;
        a = d ? AW'(NA - 1 - i) : AW'(i);
        for (int s = 0; s < len; s++) begin
          bit wr, inv;
          logic [DW-1:0] v;
          case (op)
            1: begin wr = 1; inv = 0; end
            2: begin wr = 0; inv = 0; end
            3: begin wr = (s == 1); inv = (s == 1); end
            4: begin wr = (s == 1); inv = (s >= 1); end
            default: begin wr = (s == 0 || s == 2); inv = (s >= 2); end
          endcase
          v = inv ? ~bg : bg;
          exp_q.push_back('{we: wr, addr: a, data: v});
          if (wr) mdl_mem[a] = v;
          else if (seen(mdl_mem[a], a) != v) begin exp_pass = 0; return; end
        end
      end
    end
    exp_pass = 1;
  endtask

  // compare every request against the expected list
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (mem_we && !mem_en) chk(0, "R11 write select without request", 1, 0);
      if (mem_en) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6/R8 unexpected RAM access", 1, 0);
        end else begin
          op_rec_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we, "R4 operation kind", mem_we, e.we);
          chk(mem_addr == e.addr, "R3 address order", mem_addr, e.addr);
          if (e.we) chk(mem_wdata == e.data, "R2 background data", mem_wdata, e.data);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(!mem_en && !mem_we, "R1 no request after reset", {mem_en, mem_we}, 0);
    chk(!test_done && !test_pass, "R1 result cleared", {test_done, test_pass}, 0);
  endtask

  task automatic load(input logic [CW-1:0] c [ND]);
    for (int k = 0; k < ND; k++)
      for (int b = 0; b < CW; b++) begin
        @(negedge clk); scan_en = 1; scan_in = c[k][b];
      end
    @(negedge clk); scan_en = 0; scan_in = 0;
  endtask

  task automatic run(input string tag, input logic [CW-1:0] c [ND], input bit noise);
    int n;
    build(c);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (noise) begin
      // R9: loading inputs and start toggled during the run
      for (int i = 0; i < 8; i++) begin
        scan_en = 1; scan_in = i[0]; start = (i == 4);
        @(negedge clk);
      end
      scan_en = 0; scan_in = 0; start = 0;
    end else begin
      repeat (2) @(negedge clk);
    end
    n = 0;
    while (!test_done && n < 5000) begin @(negedge clk); n++; end
    chk(test_done == 1, {tag, " done"}, test_done, 1);
    chk(test_pass == exp_pass, {tag, " result"}, test_pass, exp_pass);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all accesses issued"}, exp_q.size(), 0);
  endtask

  logic [CW-1:0] cs [ND];

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    for (int i = 0; i < NA; i++) begin ram[i] = '0; mdl_mem[i] = '0; end
    mem_rdata = '0;
    do_reset();

    // R3 R4 R6: ascending and descending commands, ended by a null
    cs[0] = mk(0, 4'd1, 8'h55); cs[1] = mk(0, 4'd4, 8'h55);
    cs[2] = mk(1, 4'd3, 8'hAA); cs[3] = mk(0, 4'd0, 8'h00);
    load(cs);
    run("R6 null ends with pass", cs, 0);

    // R10 R9: rerun of the same program with noise on the inputs
    run("R10 rerun after pass", cs, 1);
    run("R9 inputs ignored while running", cs, 0);

    // R5 R7: full-length op, a skipped code, no null in any slot
    cs[0] = mk(1, 4'd5, 8'h0F); cs[1] = mk(0, 4'd9, 8'h3C);
    cs[2] = mk(0, 4'd2, 8'hF0); cs[3] = mk(1, 4'd2, 8'hF0);
    load(cs);
    run("R5 R7 skipped code and end of buffer", cs, 0);

    // R8: stuck bit gives fail, which holds through start
    flt_on = 1; flt_addr = 4'd6; flt_bit = 0; flt_val = 1'b1;
    cs[0] = mk(0, 4'd1, 8'h00); cs[1] = mk(0, 4'd2, 8'h00);
    cs[2] = mk(0, 4'd0, 8'h00); cs[3] = mk(0, 4'd0, 8'h00);
    load(cs);
    run("R8 mismatch gives fail", cs, 0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(test_done && !test_pass, "R8 fail holds after start",
        {test_done, test_pass}, 2'b10);
    flt_on = 0;
    do_reset();

    // R1: buffer cleared by reset acts as null
    cs[0] = '0; cs[1] = '0; cs[2] = '0; cs[3] = '0;
    run("R1 cleared buffer is null", cs, 0);

    // R6: null with nonzero fields, valid commands after it never run
    cs[0] = mk(1, 4'd0, 8'hFF); cs[1] = mk(0, 4'd1, 8'h11);
    cs[2] = mk(0, 4'd2, 8'h11); cs[3] = mk(0, 4'd5, 8'h22);
    load(cs);
    run("R6 null first", cs, 0);

    summary();
  end
endmodule